// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block gathers a set of device interrupt request lines and drives one interrupt signal toward the processor. Software sets up each line through a small register port. For every line it can hide the line, choose whether the line reacts to a rising edge or to a held level, and assign a priority. Software also sets a vector base that applies to all lines.

When the processor pulses its acknowledge, the controller selects the winning request among the unmasked pending lines. It returns that line's vector one cycle later, and the vector is the base plus the line index. If nothing qualifies at the moment of the acknowledge, it returns a fixed spurious vector instead. A spurious return happens, for example, when a level request was withdrawn before the processor got round to answering.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every line is masked and edge-triggered, every priority is 0, the base is 32, and `int_out` and `ack_valid` are low.
- R2: A rising edge on a masked line is not latched, and a masked line never drives `int_out`.
- R3: On an unmasked edge-mode line, a rising input edge sets the line's pending state one cycle later. The state is held until an acknowledge selects that line. A rising edge in the same cycle as that acknowledge keeps it pending. An input that stays high does not re-latch.
- R4: A level-mode line is pending exactly while its input is high. An acknowledge does not clear it.
- R5: `int_out` is high exactly when at least one unmasked line is pending. It follows a level input in the same cycle.
- R6: At acknowledge, the line with the numerically largest priority field wins, and among equal fields the lower line index wins.
- R7: One cycle after a one-cycle `cpu_ack`, `ack_valid` is high for one cycle and `ack_vec` = base + winning line index, modulo 256.
- R8: If no unmasked line is pending in the acknowledge cycle, `ack_vec` is 8'hFF.
- R9: Register map by `reg_addr`. Address 0 is the mask, where bit i = 1 hides line i. Address 1 is the mode, where bit i = 1 selects level. Address 2 holds the priorities, with line i in bits [3i+2:3i]. Address 3 holds the base in bits [7:0]. Reads return the value combinationally, zero-extended. A write takes effect at the clock edge.
- R10: While a line is in level mode its latched edge state is cleared, so an edge taken before a switch to level mode is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| irq_in | input | 8 | device request lines, active high, synchronous to clk |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 2 | register select |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data |
| int_out | output | 1 | interrupt toward the processor |
| cpu_ack | input | 1 | acknowledge pulse from the processor |
| ack_valid | output | 1 | vector valid, one cycle after acknowledge |
| ack_vec | output | 8 | returned vector |

## Verification
The bench builds the block with its defaults: eight lines, three-bit priority fields, a reset base of 32 and a spurious vector of 255. Eight lines with three-bit priorities allow equal-priority ties between non-adjacent lines and a full ordering of three requests. The 8-bit vector allows a base near the top of the range, where base plus line index wraps past 255. With that base, the bench also confirms that the wrapped result is kept distinct from the spurious code.

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl #(
  parameter int N_LINES    = 8,
  parameter int PRIO_W     = 3,
  parameter int VEC_W      = 8,
  parameter int RESET_BASE = 32,
  parameter int SPUR_VEC   = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        irq_in,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              int_out,
  input  logic              cpu_ack,
  output logic              ack_valid,
  output logic [7:0]        ack_vec
);
  localparam int PRIO_BITS = N_LINES * PRIO_W;
  localparam int LW = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic [N_LINES-1:0]   mask_q, mode_q, edge_pend, prev_q, pending, act;
  logic [PRIO_BITS-1:0] prio_q;
  logic [VEC_W-1:0]     base_q;
  logic                 found;
  logic [LW-1:0]        win;
  logic [PRIO_W-1:0]    best;

  assign pending = (mode_q & irq_in[N_LINES-1:0]) | (~mode_q & edge_pend);
  assign act     = pending & ~mask_q;
  assign int_out = |act;

  always_comb begin
    found = 1'b0;
    win   = '0;
    best  = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (act[i] && (!found || prio_q[i*PRIO_W +: PRIO_W] > best)) begin
        found = 1'b1;
        win   = LW'(i);
        best  = prio_q[i*PRIO_W +: PRIO_W];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata[N_LINES-1:0]   = mask_q;
      2'd1: reg_rdata[N_LINES-1:0]   = mode_q;
      2'd2: reg_rdata[PRIO_BITS-1:0] = prio_q;
      default: reg_rdata[VEC_W-1:0]  = base_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      mode_q <= '0;
      prio_q <= '0;
      base_q <= VEC_W'(RESET_BASE);
    end else if (reg_we) begin
      case (reg_addr)
        2'd0: mask_q <= reg_wdata[N_LINES-1:0];
        2'd1: mode_q <= reg_wdata[N_LINES-1:0];
        2'd2: prio_q <= reg_wdata[PRIO_BITS-1:0];
        default: base_q <= reg_wdata[VEC_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      edge_pend <= '0;
    end else begin
      prev_q <= irq_in[N_LINES-1:0];
      for (int i = 0; i < N_LINES; i++) begin
        if (mode_q[i])
          edge_pend[i] <= 1'b0;
        else if (irq_in[i] && !prev_q[i] && !mask_q[i])
          edge_pend[i] <= 1'b1;
        else if (cpu_ack && found && win == LW'(i))
          edge_pend[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid <= 1'b0;
      ack_vec   <= '0;
    end else begin
      ack_valid <= cpu_ack;
      if (cpu_ack)
        ack_vec <= found ? (base_q + VEC_W'(win)) : VEC_W'(SPUR_VEC);
    end
  end

  a_r7_valid_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> $past(cpu_ack));

  a_r8_spurious_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !int_out) |=> (ack_valid && ack_vec == VEC_W'(SPUR_VEC)));

  a_r7_vec_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && $past(int_out)) |-> (VEC_W'(ack_vec - $past(base_q)) < VEC_W'(N_LINES)));

  for (genvar g = 0; g < N_LINES; g++) begin : g_chk
    a_r3_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_pend[g] && !cpu_ack && !mode_q[g] && !(reg_we && reg_addr == 2'd1)) |=> edge_pend[g]);
    a_r2_masked_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[g] && !edge_pend[g]) |=> !edge_pend[g]);
  end
endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  logic clk = 0, rst_n = 0;
  logic [7:0] irq_in = 0;
  logic reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic int_out, cpu_ack = 0, ack_valid;
  logic [7:0] ack_vec;

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  irq_prio_ctrl u0 (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int_out(int_out), .cpu_ack(cpu_ack), .ack_valid(ack_valid), .ack_vec(ack_vec));

  // behavioural reference
  bit [7:0] m_mask = 8'hFF, m_mode = 0, m_ep = 0, m_prev = 0;
  int m_prio[8];
  int m_base = 32;
  bit m_av = 0;
  int m_vec = 0;

  function automatic int winner(output bit any);
    int w = -1, bp = -1;
    for (int i = 0; i < 8; i++) begin
      bit p = m_mode[i] ? irq_in[i] : m_ep[i];
      if (p && !m_mask[i] && m_prio[i] > bp) begin w = i; bp = m_prio[i]; end
    end
    any = (w >= 0);
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = 8'hFF; m_mode = 0; m_ep = 0; m_prev = 0; m_base = 32; m_av = 0;
      for (int i = 0; i < 8; i++) m_prio[i] = 0;
    end else begin
      bit any; int w;
      bit [7:0] nep;
      w = winner(any);
      for (int i = 0; i < 8; i++) begin
        if (m_mode[i]) nep[i] = 0;
        else if (irq_in[i] && !m_prev[i] && !m_mask[i]) nep[i] = 1;
        else if (cpu_ack && any && w == i) nep[i] = 0;
        else nep[i] = m_ep[i];
      end
      m_av = cpu_ack;
      if (cpu_ack) m_vec = any ? ((m_base + w) % 256) : 255;
      m_ep = nep;
      m_prev = irq_in;
      if (reg_we) begin
        case (reg_addr)
          2'd0: m_mask = reg_wdata[7:0];
          2'd1: m_mode = reg_wdata[7:0];
          2'd2: for (int i = 0; i < 8; i++) m_prio[i] = (reg_wdata >> (3*i)) & 7;
          default: m_base = reg_wdata[7:0];
        endcase
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    bit any; int w;
    w = winner(any);
    check({phase, " int_out (R5)"}, int_out, any);
    check({phase, " ack_valid (R7)"}, ack_valid, m_av);
    if (m_av) check({phase, (m_vec == 255) ? " ack_vec R8" : " ack_vec R6/R7"}, ack_vec, m_vec);
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 0;
  endtask

  task automatic rd(logic [1:0] a, int exp, string tag);
    reg_addr = a;
    @(negedge clk);
    check(tag, reg_rdata, exp);
    step();
  endtask

  task automatic ack();
    cpu_ack = 1; step(); cpu_ack = 0; step();
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr = 16'hACE1;
    step(3);
    @(negedge clk);
    check("R1 int_out at reset", int_out, 0);
    check("R1 ack_valid at reset", ack_valid, 0);
    rst_n = 1;
    step();
    rd(2'd0, 8'hFF, "R1 R9 mask reset");
    rd(2'd1, 0, "R1 R9 mode reset");
    rd(2'd2, 0, "R1 R9 prio reset");
    rd(2'd3, 32, "R1 R9 base reset");

    phase = "R2";
    irq_in = 8'h01; step(2); irq_in = 0; step(2);
    wr(2'd0, 32'hFE); step(2);
    check("R2 masked edge not latched", int_out, 0);
    wr(2'd0, 32'h00);
    rd(2'd0, 0, "R9 mask readback");

    phase = "R3";
    irq_in = 8'h02; step(3);
    check("R3 edge latched", int_out, 1);
    ack();
    check("R3 cleared after ack", int_out, 0);
    ack();
    phase = "R8";
    ack();
    phase = "R3";
    irq_in = 8'h00; step();
    irq_in = 8'h02; step();
    cpu_ack = 1; irq_in = 8'h00; step(); cpu_ack = 0; step();
    irq_in = 8'h02; cpu_ack = 1; step(); cpu_ack = 0; step();
    irq_in = 0; step();
    check("R3 edge in ack cycle stays pending", int_out, 1);
    ack();

    phase = "R6";
    wr(2'd2, (5 << 6) | (5 << 15) | (3 << 18));
    rd(2'd2, (5 << 6) | (5 << 15) | (3 << 18), "R9 prio readback");
    irq_in = 8'h64; step(); irq_in = 0; step();
    ack(); ack(); ack(); ack();

    phase = "R4";
    wr(2'd1, 32'h08);
    irq_in = 8'h08;
    @(negedge clk);
    check("R4 level int same cycle", int_out, 1);
    step();
    ack();
    check("R4 level survives ack", int_out, 1);
    irq_in = 0; step();
    phase = "R8";
    ack();

    phase = "R10";
    irq_in = 8'h10; step(); irq_in = 0; step();
    wr(2'd1, 32'h18);
    wr(2'd1, 32'h08);
    step();
    check("R10 edge lost on level switch", int_out, 0);

    phase = "R7";
    wr(2'd3, 32'h40);
    irq_in = 8'h80; step(); irq_in = 0; step();
    ack();
    wr(2'd3, 32'hF9);
    rd(2'd3, 8'hF9, "R9 base readback");
    irq_in = 8'h80; step(); irq_in = 0; step();
    ack();

    phase = "R5";
    wr(2'd0, 32'h21);
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      irq_in = lfsr[7:0];
      cpu_ack = lfsr[9] & lfsr[11];
      step();
    end
    cpu_ack = 0; irq_in = 0; step(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule